// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a 16-bit up-counter held as two byte lanes, with a 16-bit compare value beside it. It counts either a free-running tick input (timer mode) or rising edges of an external line (counter mode). When the count passes its top value it wraps to zero and latches an overflow flag, which can raise an interrupt. When the count reaches the compare value, a match flag is latched. In special-event mode the match also clears the count and can send a one-cycle start pulse to an A/D converter, so that sampling repeats at a fixed hardware period.

Software reaches the block through a byte-wide register port. Writes take effect at the next clock edge, and reads are combinational from a separate read address. The byte offsets are: 0 count low, 1 count high, 2 compare low, 3 compare high, 4 control, 5 status. The control bits are: bit0 run, bit1 source (0 = tick, 1 = external edges), bit2 special-event enable, bit3 overflow interrupt enable. The status bits are: bit0 overflow, bit1 match. The upper bits of control and status read as zero. The register port has no back-pressure: every write is accepted in the cycle in which it is presented.

Top module: `tmr16_compare`

## Requirements
- R1: After reset, the count, the compare value, the control and the status all read 0, and `adc_start` and `irq` are low.
- R2: A write to offset 0, 1, 2, 3 or 4 replaces only the addressed byte, and that byte reads back the written value from the next cycle on. A write to one count byte leaves the other count byte unchanged.
- R3: With run=1 and source=0, the count advances by one for each clock edge at which `tick` is high.
- R4: With run=1 and source=1, the count advances by one for each clock edge at which `ext_in` is 1 and was 0 at the previous edge. `tick` is ignored in this mode.
- R5: With run=0, the count holds its value whatever `tick` and `ext_in` do.
- R6: A count step taken from FFFFh gives 0000h and sets status bit0. `irq` is high exactly while status bit0 and control bit3 are both 1.
- R7: A count step taken while the count equals the compare value sets status bit1, whether or not special-event mode is on.
- R8: In special-event mode, a count step taken at the compare value loads 0 instead of incrementing, so the period is compare+1 steps. When the compare value is FFFFh, this clear does not set the overflow flag.
- R9: `adc_start` is high for the one cycle after each special-event match, and only if `adc_enable` was high in the cycle of the match.
- R10: Writing status with a bit at 1 clears that flag, and a 0 bit leaves it unchanged. A flag that is set and cleared in the same cycle ends up set.
- R11: In a cycle with a write to a count byte, the count neither steps nor produces a match, even when a count event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 8 | Register write byte |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 8 | Register read byte (combinational) |
| tick | input | 1 | Internal count enable for timer mode |
| ext_in | input | 1 | External pulse line for counter mode |
| adc_enable | input | 1 | Allows special-event start pulses |
| adc_start | output | 1 | One-cycle converter start pulse |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with its default parameters: two 8-bit lanes, which gives a 16-bit count and a 3-bit offset. Preloading the count through the byte port puts the FFFFh wrap and the FFFFh compare case a few steps away. Small compare values put every special-event period from 1 to 12 steps within reach, and the bench sweeps all of them, counting start pulses and checking the final count. Tick and edge patterns are generated arithmetically, so the expected counts follow from the pattern alone.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_BITS = 4;
  localparam int STAT_OVF  = 0;
  localparam int STAT_HIT  = 1;
  localparam int STAT_BITS = 2;

  // bit0 run, bit1 source, bit2 special event, bit3 overflow irq enable
  typedef struct packed {
    logic ovf_ie;
    logic spec_en;
    logic ext_sel;
    logic run;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_event_sel.sv
module tmr_event_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ext_sel,
  input  logic tick,
  input  logic ext_in,
  output logic count_evt
);
  logic ext_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_prev <= 1'b0;
    else        ext_prev <= ext_in;
  end

  always_comb begin
    if (!run)        count_evt = 1'b0;
    else if (ext_sel) count_evt = ext_in & ~ext_prev;
    else             count_evt = tick;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              count_evt,
  input  logic [NBYTES-1:0] lane_wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [W-1:0]      cmp_val,
  input  logic              spec_en,
  output logic [W-1:0]      tmr_q,
  output logic              match_evt,
  output logic              ovf_evt
);
  logic         any_wr;
  logic         clear;
  logic [W-1:0] tmr_inc;

  assign any_wr    = |lane_wr;
  assign tmr_inc   = tmr_q + W'(1);
  assign match_evt = count_evt & ~any_wr & (tmr_q == cmp_val);
  assign clear     = match_evt & spec_en;
  assign ovf_evt   = count_evt & ~any_wr & (&tmr_q) & ~clear;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)          tmr_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (lane_wr[i]) tmr_q[i*BYTE_W +: BYTE_W] <= wr_data;
      else if (any_wr)     tmr_q[i*BYTE_W +: BYTE_W] <= tmr_q[i*BYTE_W +: BYTE_W];
      else if (clear)      tmr_q[i*BYTE_W +: BYTE_W] <= '0;
      else if (count_evt)  tmr_q[i*BYTE_W +: BYTE_W] <= tmr_inc[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int W      = BYTE_W * NBYTES,
  localparam int ADDR_W = $clog2(2 * NBYTES + 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic                 match_evt,
  input  logic                 ovf_evt,
  input  logic [W-1:0]         tmr_q,
  output logic [W-1:0]         cmp_val,
  output tmr_ctrl_t            ctrl,
  output logic [NBYTES-1:0]    lane_wr,
  output logic [STAT_BITS-1:0] stat,
  output logic [BYTE_W-1:0]    rd_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2 * NBYTES);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2 * NBYTES + 1);

  logic                 stat_wr;
  logic [STAT_BITS-1:0] stat_set;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign lane_wr[i] = wr_en && (wr_addr == ADDR_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_val[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(NBYTES + i))
        cmp_val[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl <= tmr_ctrl_t'(wr_data[CTRL_BITS-1:0]);
  end

  assign stat_wr = wr_en && (wr_addr == A_STAT);
  always_comb begin
    stat_set           = '0;
    stat_set[STAT_OVF] = ovf_evt;
    stat_set[STAT_HIT] = match_evt;
  end

  for (genvar b = 0; b < STAT_BITS; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                      stat[b] <= 1'b0;
      else if (stat_set[b])            stat[b] <= 1'b1;
      else if (stat_wr && wr_data[b])  stat[b] <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (rd_addr == ADDR_W'(i))          rd_data = tmr_q[i*BYTE_W +: BYTE_W];
      if (rd_addr == ADDR_W'(NBYTES + i)) rd_data = cmp_val[i*BYTE_W +: BYTE_W];
    end
    if (rd_addr == A_CTRL) rd_data = BYTE_W'(ctrl);
    if (rd_addr == A_STAT) rd_data = BYTE_W'(stat);
  end
endmodule

// File: rtl/tmr16_compare.sv
module tmr16_compare
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int ADDR_W = $clog2(2 * NBYTES + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tick,
  input  logic              ext_in,
  input  logic              adc_enable,
  output logic              adc_start,
  output logic              irq
);
  localparam int W = BYTE_W * NBYTES;

  tmr_ctrl_t            ctrl_q;
  logic [W-1:0]         cmp_val;
  logic [W-1:0]         tmr_q;
  logic [NBYTES-1:0]    lane_wr;
  logic [STAT_BITS-1:0] stat;
  logic                 count_evt;
  logic                 match_evt;
  logic                 ovf_evt;

  tmr_event_sel u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl_q.run),
    .ext_sel   (ctrl_q.ext_sel),
    .tick      (tick),
    .ext_in    (ext_in),
    .count_evt (count_evt)
  );

  tmr_counter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .count_evt (count_evt),
    .lane_wr   (lane_wr),
    .wr_data   (wr_data),
    .cmp_val   (cmp_val),
    .spec_en   (ctrl_q.spec_en),
    .tmr_q     (tmr_q),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt)
  );

  tmr_regs #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .match_evt (match_evt),
    .ovf_evt   (ovf_evt),
    .tmr_q     (tmr_q),
    .cmp_val   (cmp_val),
    .ctrl      (ctrl_q),
    .lane_wr   (lane_wr),
    .stat      (stat),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) adc_start <= 1'b0;
    else        adc_start <= match_evt & ctrl_q.spec_en & adc_enable;
  end

  assign irq = stat[STAT_OVF] & ctrl_q.ovf_ie;
endmodule

// File: rtl/tmr16_compare_chk.sv
module tmr16_compare_chk #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2,
  localparam int W = BYTE_W * NBYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adc_start,
  input logic              adc_enable,
  input logic [W-1:0]      tmr_q,
  input logic              ovf_flag,
  input logic              hit_flag,
  input logic              run,
  input logic [NBYTES-1:0] lane_wr,
  input logic [BYTE_W-1:0] wr_data
);
  assert_adc_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $past(adc_enable));

  assert_adc_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> (tmr_q == '0));

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (tmr_q == '0));

  assert_hold_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(|lane_wr)) |=> $stable(tmr_q));

  assert_low_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr[0] |=> (tmr_q[BYTE_W-1:0] == $past(wr_data)));

  assert_no_hit_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_flag) |-> !$past(|lane_wr));
endmodule

bind tmr16_compare tmr16_compare_chk #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adc_start  (adc_start),
  .adc_enable (adc_enable),
  .tmr_q      (tmr_q),
  .ovf_flag   (stat[0]),
  .hit_flag   (stat[1]),
  .run        (ctrl_q.run),
  .lane_wr    (lane_wr),
  .wr_data    (wr_data)
);

// File: tb/tmr16_compare_test.sv
`timescale 1ns/100ps
module tmr16_compare_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick = 1'b0;
  logic       ext_in = 1'b0;
  logic       adc_enable = 1'b0;
  logic       adc_start;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tmr16_compare uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .ext_in(ext_in),
    .adc_enable(adc_enable), .adc_start(adc_start), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = a[2:0];
    #0.1;
    v = int'(rd_data);
  endtask

  task automatic rd16(input int base, output int v);
    int lo, hi;
    rd(base, lo);
    rd(base + 1, hi);
    v = (hi << 8) | lo;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input int tval, input int cval);
    wr(4, 0);
    wr(0, tval & 8'hFF); wr(1, tval >> 8);
    wr(2, cval & 8'hFF); wr(3, cval >> 8);
    wr(5, 3);
  endtask

  // special-event period sweep: count start pulses over three periods
  task automatic period_run(input int c, input bit en);
    int pulses = 0;
    int v;
    int n = 3 * (c + 1);
    setup(0, c);
    adc_enable = en;
    wr(4, 5);
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (adc_start) pulses++;
    end
    tick = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      if (adc_start) pulses++;
    end
    chk($sformatf("R9 pulses cmp=%0d en=%0d", c, en), pulses, en ? 3 : 0);
    rd16(0, v);
    chk($sformatf("R8 count after periods cmp=%0d", c), v, 0);
    rd(5, v);
    chk($sformatf("R7 R8 status cmp=%0d", c), v, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v, exp, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, v);
      chk($sformatf("R1 reg %0d", a), v, 0);
    end
    chk("R1 adc_start", int'(adc_start), 0);
    chk("R1 irq", int'(irq), 0);

    // R2 byte access
    wr(0, 8'h34);
    rd16(0, v); chk("R2 low byte only", v, 16'h0034);
    wr(1, 8'h12);
    wr(2, 8'hEF); wr(3, 8'hBE);
    rd16(0, v); chk("R2 count bytes", v, 16'h1234);
    rd16(2, v); chk("R2 compare bytes", v, 16'hBEEF);
    wr(4, 8'hF0);
    rd(4, v); chk("R2 control upper bits", v, 0);

    // R5 stopped: ticks and edges ignored
    @(negedge clk);
    tick = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ext_in = i[0];
    end
    tick = 1'b0; ext_in = 1'b0;
    rd16(0, v); chk("R5 hold while off", v, 16'h1234);

    // R3 timer mode, two tick patterns
    for (int p = 2; p <= 3; p++) begin
      setup(0, 16'hBEEF);
      wr(4, 1);
      exp = 0;
      for (int i = 0; i < 23; i++) begin
        @(negedge clk);
        tick = (i % p) != 0;
        if (tick) exp++;
      end
      @(negedge clk);
      tick = 1'b0;
      rd16(0, v); chk($sformatf("R3 tick pattern %0d", p), v, exp);
    end

    // R4 counter mode, tick held high and ignored
    setup(0, 16'hBEEF);
    wr(4, 3);
    exp = 0; prev = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      ext_in = ((20'hB6E5D >> i) & 1) != 0;
      tick = 1'b1;
      if (ext_in && prev == 0) exp++;
      prev = int'(ext_in);
    end
    @(negedge clk);
    ext_in = 1'b0; tick = 1'b0;
    rd16(0, v); chk("R4 external rising edges", v, exp);

    // R6 rollover and interrupt
    setup(16'hFFFD, 16'h1000);
    wr(4, 9);
    ticks(2);
    rd16(0, v); chk("R6 at top", v, 16'hFFFF);
    rd(5, v);   chk("R6 no flag before wrap", v, 0);
    chk("R6 irq low before wrap", int'(irq), 0);
    ticks(1);
    rd16(0, v); chk("R6 wrapped", v, 0);
    rd(5, v);   chk("R6 overflow flag", v, 1);
    chk("R6 irq raised", int'(irq), 1);
    wr(4, 1);
    chk("R6 irq masked", int'(irq), 0);

    // R10 write-one-to-clear
    wr(5, 0);
    rd(5, v); chk("R10 zero write keeps flag", v, 1);
    wr(5, 1);
    rd(5, v); chk("R10 flag cleared", v, 0);
    setup(16'hFFFF, 16'h1000);
    wr(4, 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h01;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(5, v); chk("R10 set wins over clear", v, 1);

    // R7 match without special event
    setup(0, 5);
    wr(4, 1);
    ticks(5);
    rd(5, v); chk("R7 no flag before step at compare", v, 0);
    ticks(1);
    rd(5, v);   chk("R7 match flag", v, 2);
    rd16(0, v); chk("R7 count continues", v, 6);

    // R8 R9 period sweep
    for (int c = 0; c < 12; c++) period_run(c, 1'b1);
    period_run(3, 1'b0);

    // R8 compare at top value: clear without overflow
    setup(16'hFFFE, 16'hFFFF);
    adc_enable = 1'b1;
    wr(4, 5);
    ticks(2);
    rd16(0, v); chk("R8 cleared at FFFF", v, 0);
    rd(5, v);   chk("R8 match but no overflow", v, 2);

    // R11 write during count event
    setup(0, 16'h0010);
    wr(4, 1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h10;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd16(0, v); chk("R11 write wins over step", v, 16'h0010);
    rd(5, v);   chk("R11 no match on write", v, 0);
    ticks(1);
    rd(5, v);   chk("R11 match on next step", v, 2);
    rd16(0, v); chk("R11 step after write", v, 16'h0011);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule